// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer holding 64 words of 36 bits. Words enter on a write clock and leave on a read clock that need bear no relation to it. Four active-low status outputs report its state. Two describe the hard limits: `full_n` on the write side and `empty_n` on the read side. Two give early warnings: `almost_full_n` and `almost_empty_n`. Both warnings use a shared threshold X.

X is chosen by a two-bit select input. It is captured while reset is held and frozen once reset is released. Each side keeps a binary pointer with one extra wrap bit. The pointer crosses to the other side in Gray code through a two-flop synchronizer. Each flag is therefore pessimistic: it may report a fuller or emptier state than the true one for a few cycles, but never an optimistic one.

The single reset input is active low and may change at any time. Each clock domain brings it in through its own two-stage synchronizer and then applies it synchronously. A user holds reset for at least four edges of each clock before writing.

Top module: `xclk_flag_fifo`

## Requirements
- R1: A word on `wr_data` is stored on a rising `wr_clk` edge only when `wr_sel_n`=0, `wr_en`=1 and `full_n`=1. With `wr_sel_n`=1 or `wr_en`=0 nothing is stored.
- R2: On a rising `rd_clk` edge with `rd_sel_n`=0, `rd_en`=1 and `empty_n`=1, `rd_data` takes the oldest stored word. Otherwise `rd_data` holds its value.
- R3: While reset is held (four or more edges of each clock), the outputs are `full_n`=0, `empty_n`=0, `almost_empty_n`=0, `almost_full_n`=1 and `rd_data`=0.
- R4: Suppose `rst_n` rises between two `wr_clk` edges. Then `full_n` is still 0 after the first following `wr_clk` rising edge and is 1 after the second. `empty_n` and `almost_empty_n` stay 0 until data is written.
- R5: X is captured from `ofs_sel` while reset is held: `ofs_sel`=3 gives 16, 2 gives 12, 1 gives 8 and 0 gives 4. Changes of `ofs_sel` after reset release do not move the thresholds.
- R6: `full_n` is 0 when the write side sees 64 stored words. A write attempted then is dropped: it never appears on the read side.
- R7: `empty_n` is 0 when the read side sees no stored word. A read attempted then leaves `rd_data` unchanged.
- R8: Once settled, `almost_empty_n` is 0 exactly when X or fewer words are stored.
- R9: Once settled, `almost_full_n` is 0 exactly when X or fewer free locations remain.
- R10: With both clocks running and reads and writes overlapping, every accepted word is read exactly once, in write order. Each synchronized pointer moves by one Gray-code bit per update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, independent of `wr_clk` |
| rst_n | input | 1 | Active-low reset, may change asynchronously |
| ofs_sel | input | 2 | Threshold select, captured during reset |
| wr_sel_n | input | 1 | Write-side select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Low when no free location (write-side view) |
| almost_full_n | output | 1 | Low when X or fewer free locations |
| rd_sel_n | input | 1 | Read-side select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | 36 | Last word read |
| empty_n | output | 1 | Low when no stored word (read-side view) |
| almost_empty_n | output | 1 | Low when X or fewer stored words |

## Verification
A write accepted on the write clock and a read taken on the read clock can land in the same instant. When that happens, each side's flags must stay correct while the other side's pointer is still in flight through the synchronizer. This is provoked by a streaming run with write and read clocks of unequal periods and idle gaps of different rhythm on each side. The writer is faster, so the buffer repeatedly reaches full while the reader keeps draining. The run is judged by comparing every word read against a queue of the words the bench saw accepted, and by the final count of words read.

// File: rtl/xff_pkg.sv
// Shared helpers for the dual-clock threshold FIFO.
// Assumes the threshold select is two bits wide.
package xff_pkg;
    localparam int OFS_SEL_W = 2;
    localparam int OFS_STEP_LOG2 = 2;

    // Threshold decode: step of four per select code, code 0 giving four.
    function automatic logic [7:0] ofs_decode(input logic [OFS_SEL_W-1:0] sel);
        return ({6'd0, sel} + 8'd1) << OFS_STEP_LOG2;
    endfunction
endpackage

// File: rtl/xff_rst_sync.sv
// Brings the asynchronous active-low reset into one clock domain.
// Assumes reset is held for at least two edges of clk; output is a
// synchronous active-low reset for that domain.
module xff_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] pipe_q;

    // Shift the raw reset level through the synchronizing stages.
    always_ff @(posedge clk) begin
        pipe_q <= {pipe_q[STAGES-2:0], arst_n};
    end

    assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/xff_ptr_xfer.sv
// Carries a binary pointer from a source clock domain to a destination
// domain as Gray code through two flops, converting back to binary.
// Assumes the source pointer advances by at most one per source edge.
module xff_ptr_xfer #(
    parameter int PW = 7
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic [PW-1:0] src_bin_nxt,
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    output logic [PW-1:0] dst_bin
);
    logic [PW-1:0] gray_q;
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    // Register the Gray form of the next pointer in the source domain.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) gray_q <= '0;
        else            gray_q <= src_bin_nxt ^ (src_bin_nxt >> 1);
    end

    // Two-flop synchronizer in the destination domain.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_q;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the parity of itself and all bits above.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            dst_bin[i] = ^(sync_q >> i);
        end
    end

    AST_GRAY_ONE_STEP: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1); // R10
endmodule

// File: rtl/xff_wr_ctl.sv
// Write-side control: write pointer, threshold capture, full and
// almost-full flags. Assumes rd_ptr_sync is the read pointer already
// brought into this domain; rst_n is synchronous to clk.
module xff_wr_ctl #(
    parameter int DEPTH = 64,
    parameter int AW = 6,
    parameter int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ofs_sel,
    input  logic          sel_n,
    input  logic          en,
    input  logic [PW-1:0] rd_ptr_sync,
    output logic [AW-1:0] addr,
    output logic [PW-1:0] ptr_nxt,
    output logic          fire,
    output logic          full_n,
    output logic          almost_full_n
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ofs_q;
    logic [PW-1:0] fill;
    logic [PW-1:0] free;
    logic          is_full;

    // Capture the threshold while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) ofs_q <= PW'(xff_pkg::ofs_decode(ofs_sel));
    end

    // Occupancy as seen from the write side.
    always_comb begin
        fill    = ptr_q - rd_ptr_sync;
        free    = DEPTH_P - fill;
        is_full = (fill == DEPTH_P);
    end

    assign fire    = rst_n & ~sel_n & en & ~is_full;
    assign ptr_nxt = ptr_q + {{(PW-1){1'b0}}, fire};
    assign addr    = ptr_q[AW-1:0];

    // Advance the write pointer on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_nxt;
    end

    assign full_n        = rst_n & ~is_full;
    assign almost_full_n = ~rst_n | (free > ofs_q);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH_P); // R6
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !sel_n && en) |=> (ptr_q == $past(ptr_q))); // R6
    AST_AF_COVERS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !almost_full_n); // R9
    AST_OFS_HOLD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ofs_q)); // R5
endmodule

// File: rtl/xff_rd_ctl.sv
// Read-side control: read pointer, threshold capture, empty and
// almost-empty flags. Assumes wr_ptr_sync is the write pointer already
// brought into this domain; rst_n is synchronous to clk.
module xff_rd_ctl #(
    parameter int AW = 6,
    parameter int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ofs_sel,
    input  logic          sel_n,
    input  logic          en,
    input  logic [PW-1:0] wr_ptr_sync,
    output logic [AW-1:0] addr,
    output logic [PW-1:0] ptr_nxt,
    output logic          fire,
    output logic          empty_n,
    output logic          almost_empty_n
);
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ofs_q;
    logic [PW-1:0] level;
    logic          is_empty;

    // Capture the threshold while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) ofs_q <= PW'(xff_pkg::ofs_decode(ofs_sel));
    end

    // Occupancy as seen from the read side.
    always_comb begin
        level    = wr_ptr_sync - ptr_q;
        is_empty = (level == '0);
    end

    assign fire    = rst_n & ~sel_n & en & ~is_empty;
    assign ptr_nxt = ptr_q + {{(PW-1){1'b0}}, fire};
    assign addr    = ptr_q[AW-1:0];

    // Advance the read pointer on each word taken.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_nxt;
    end

    assign empty_n        = rst_n & ~is_empty;
    assign almost_empty_n = rst_n & (level > ofs_q);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PW'(1 << AW)); // R7
    AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !sel_n && en) |=> (ptr_q == $past(ptr_q))); // R7
    AST_AE_COVERS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n); // R8
    AST_OFS_HOLD_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ofs_q)); // R5
endmodule

// File: rtl/xff_mem.sv
// Storage array: written on the write clock, read into a registered
// output on the read clock. Assumes the controls never read a location
// that is being written in the same instant.
module xff_mem #(
    parameter int DW = 36,
    parameter int DEPTH = 64,
    parameter int AW = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    // Store the accepted word.
    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Load the output register on a read; hold otherwise.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) rdata <= '0;
        else if (re)   rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/xclk_flag_fifo.sv
// Top level of the dual-clock FIFO with threshold flags. Ties the reset
// synchronizers, both side controls, the pointer crossings and the array.
// Assumes rst_n is held for at least four edges of each clock.
module xclk_flag_fifo #(
    parameter int DW = 36,
    parameter int DEPTH = 64
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic [1:0]    ofs_sel,
    input  logic          wr_sel_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full_n,
    output logic          almost_full_n,
    input  logic          rd_sel_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          almost_empty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int NDOM = 2;

    logic [NDOM-1:0] dom_clk;
    logic [NDOM-1:0] dom_rst_n;
    logic            wr_rst_n;
    logic            rd_rst_n;
    logic [AW-1:0]   wr_addr;
    logic [AW-1:0]   rd_addr;
    logic [PW-1:0]   wr_ptr_nxt;
    logic [PW-1:0]   rd_ptr_nxt;
    logic [PW-1:0]   wr_ptr_at_rd;
    logic [PW-1:0]   rd_ptr_at_wr;
    logic            wr_fire;
    logic            rd_fire;

    assign dom_clk  = {rd_clk, wr_clk};
    assign wr_rst_n = dom_rst_n[0];
    assign rd_rst_n = dom_rst_n[1];

    // One reset synchronizer per clock domain.
    for (genvar d = 0; d < NDOM; d++) begin : g_rst
        xff_rst_sync #(.STAGES(2)) u_sync (
            .clk    (dom_clk[d]),
            .arst_n (rst_n),
            .srst_n (dom_rst_n[d])
        );
    end

    xff_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk           (wr_clk),
        .rst_n         (wr_rst_n),
        .ofs_sel       (ofs_sel),
        .sel_n         (wr_sel_n),
        .en            (wr_en),
        .rd_ptr_sync   (rd_ptr_at_wr),
        .addr          (wr_addr),
        .ptr_nxt       (wr_ptr_nxt),
        .fire          (wr_fire),
        .full_n        (full_n),
        .almost_full_n (almost_full_n)
    );

    xff_rd_ctl #(.AW(AW), .PW(PW)) u_rd (
        .clk            (rd_clk),
        .rst_n          (rd_rst_n),
        .ofs_sel        (ofs_sel),
        .sel_n          (rd_sel_n),
        .en             (rd_en),
        .wr_ptr_sync    (wr_ptr_at_rd),
        .addr           (rd_addr),
        .ptr_nxt        (rd_ptr_nxt),
        .fire           (rd_fire),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n)
    );

    xff_ptr_xfer #(.PW(PW)) u_w2r (
        .src_clk     (wr_clk),
        .src_rst_n   (wr_rst_n),
        .src_bin_nxt (wr_ptr_nxt),
        .dst_clk     (rd_clk),
        .dst_rst_n   (rd_rst_n),
        .dst_bin     (wr_ptr_at_rd)
    );

    xff_ptr_xfer #(.PW(PW)) u_r2w (
        .src_clk     (rd_clk),
        .src_rst_n   (rd_rst_n),
        .src_bin_nxt (rd_ptr_nxt),
        .dst_clk     (wr_clk),
        .dst_rst_n   (wr_rst_n),
        .dst_bin     (rd_ptr_at_wr)
    );

    xff_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wr_clk   (wr_clk),
        .we       (wr_fire),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .re       (rd_fire),
        .raddr    (rd_addr),
        .rdata    (rd_data)
    );
endmodule

// File: tb/xclk_flag_fifo_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module xclk_flag_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = CLK_PERIOD + 4;
    localparam int DW = 36;
    localparam int DEPTH = 64;
    localparam int N_STREAM = 300;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ofs_sel = 2'b00;
    logic          wr_sel_n = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          full_n;
    logic          almost_full_n;
    logic          rd_sel_n = 1'b1;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          empty_n;
    logic          almost_empty_n;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] exp_q [$];

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

    xclk_flag_fifo #(.DW(DW), .DEPTH(DEPTH)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_sel_n(wr_sel_n), .wr_en(wr_en), .wr_data(wr_data),
        .full_n(full_n), .almost_full_n(almost_full_n),
        .rd_sel_n(rd_sel_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        #1;
    endtask

    function automatic logic [DW-1:0] mk(input logic [1:0] s, input int n);
        return {s, 2'b10, 32'(n * 32'h01F3_9A5D + 7)};
    endfunction

    task automatic do_reset(input logic [1:0] sel, input bit check);
        rst_n = 1'b0; ofs_sel = sel;
        wr_en = 1'b0; wr_sel_n = 1'b1; rd_en = 1'b0; rd_sel_n = 1'b1;
        repeat (5) @(posedge wr_clk);
        repeat (5) @(posedge rd_clk);
        #1;
        if (check) begin
            chk("R3 full_n in reset", 64'(full_n), 64'd0);
            chk("R3 empty_n in reset", 64'(empty_n), 64'd0);
            chk("R3 almost_empty_n in reset", 64'(almost_empty_n), 64'd0);
            chk("R3 almost_full_n in reset", 64'(almost_full_n), 64'd1);
            chk("R3 rd_data in reset", 64'(rd_data), 64'd0);
        end
        @(negedge wr_clk);
        rst_n = 1'b1;
        @(posedge wr_clk); #1;
        if (check) chk("R4 full_n after first edge", 64'(full_n), 64'd0);
        @(posedge wr_clk); #1;
        if (check) chk("R4 full_n after second edge", 64'(full_n), 64'd1);
        repeat (4) @(posedge rd_clk); #1;
        if (check) begin
            chk("R4 empty_n after release", 64'(empty_n), 64'd0);
            chk("R4 almost_empty_n after release", 64'(almost_empty_n), 64'd0);
        end
        exp_q.delete();
    endtask

    task automatic write_word(input logic [DW-1:0] d, output bit ok);
        @(negedge wr_clk);
        ok = full_n;
        wr_sel_n = 1'b0; wr_en = 1'b1; wr_data = d;
        @(posedge wr_clk);
        if (ok) exp_q.push_back(d);
        #1;
        wr_sel_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic read_word(output logic [DW-1:0] d);
        @(negedge rd_clk);
        rd_sel_n = 1'b0; rd_en = 1'b1;
        @(posedge rd_clk); #1;
        d = rd_data;
        rd_sel_n = 1'b1; rd_en = 1'b0;
    endtask

    // Fill and drain with one threshold setting; select changed after reset.
    task automatic test_offset(input logic [1:0] sel);
        int x;
        bit ok;
        logic [DW-1:0] d;
        logic [DW-1:0] last;
        x = 4 * (int'(sel) + 1);
        do_reset(sel, 1'b1);
        settle();
        ofs_sel = ~sel;
        for (int n = 1; n <= DEPTH; n++) begin
            write_word(mk(sel, n), ok);
            settle();
            chk($sformatf("R8 ae fill n=%0d x=%0d", n, x), 64'(almost_empty_n), 64'(n > x));
            chk($sformatf("R9 af fill n=%0d x=%0d", n, x), 64'(almost_full_n), 64'((DEPTH - n) > x));
        end
        chk("R6 full_n at 64 words", 64'(full_n), 64'd0);
        write_word(36'h0_DEAD_BEEF, ok);
        settle();
        chk("R6 full_n after dropped write", 64'(full_n), 64'd0);
        last = '0;
        for (int k = 1; k <= DEPTH; k++) begin
            read_word(d);
            chk($sformatf("R2 order k=%0d", k), 64'(d), 64'(mk(sel, k)));
            last = d;
            settle();
            chk($sformatf("R8 ae drain k=%0d x=%0d", k, x), 64'(almost_empty_n), 64'((DEPTH - k) > x));
            chk($sformatf("R9 af drain k=%0d x=%0d", k, x), 64'(almost_full_n), 64'(k > x));
        end
        chk("R6 dropped word absent, R7 empty_n low", 64'(empty_n), 64'd0);
        read_word(d);
        chk("R7 read while empty holds rd_data", 64'(d), 64'(last));
        ofs_sel = sel;
    endtask

    // Qualifiers: either inactive qualifier blocks the access.
    task automatic test_qualifiers();
        bit ok;
        logic [DW-1:0] d;
        do_reset(2'b00, 1'b0);
        @(negedge wr_clk); wr_sel_n = 1'b1; wr_en = 1'b1; wr_data = 36'h1_1111_1111;
        @(negedge wr_clk); wr_sel_n = 1'b0; wr_en = 1'b0;
        @(negedge wr_clk); wr_sel_n = 1'b1;
        settle();
        chk("R1 unqualified writes not stored", 64'(empty_n), 64'd0);
        write_word(36'h5_A5A5_0001, ok);
        settle();
        chk("R1 qualified write stored", 64'(empty_n), 64'd1);
        @(negedge rd_clk); rd_sel_n = 1'b1; rd_en = 1'b1;
        @(negedge rd_clk); rd_sel_n = 1'b0; rd_en = 1'b0;
        @(negedge rd_clk); rd_sel_n = 1'b1;
        settle();
        chk("R2 unqualified read holds rd_data", 64'(rd_data), 64'd0);
        chk("R2 unqualified read keeps word", 64'(empty_n), 64'd1);
        read_word(d);
        chk("R2 qualified read returns word", 64'(d), 64'h5_A5A5_0001);
        settle();
        chk("R7 empty after last read", 64'(empty_n), 64'd0);
    endtask

    // Overlapping reads and writes on unrelated clocks.
    task automatic test_stream();
        int got;
        do_reset(2'b01, 1'b0);
        got = 0;
        fork
            begin : writer
                bit ok;
                for (int i = 0; i < N_STREAM; i++) begin
                    if (i % 4 == 3) @(negedge wr_clk);
                    ok = 1'b0;
                    while (!ok) write_word(mk(2'b11, i + 1000), ok);
                end
            end
            begin : reader
                bit fire;
                logic [DW-1:0] e;
                for (int g = 0; g < 20000 && got < N_STREAM; g++) begin
                    @(negedge rd_clk);
                    fire = empty_n && (g % 5 != 2);
                    rd_sel_n = ~fire; rd_en = fire;
                    @(posedge rd_clk); #1;
                    rd_sel_n = 1'b1; rd_en = 1'b0;
                    if (fire) begin
                        e = exp_q.pop_front();
                        chk($sformatf("R10 stream word %0d", got), 64'(rd_data), 64'(e));
                        got++;
                    end
                end
            end
        join
        chk("R10 stream word count", 64'(got), 64'(N_STREAM));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) test_offset(2'(s));
        test_qualifiers();
        test_stream();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule